// File: doc/BRIEF.md
# Sector protection mode selector

This block keeps the lock bits that decide how the sectors of a flash device are protected, and it holds a 64-bit password. An upstream command decoder has already recognised the unlock cycles. It hands this block three things: a strobe for "program lock bits", a per-bus-cycle strobe for password-program sequences, and strobes for the two kinds of read. Each strobe comes with a 16-bit data word and a two-bit word address.

Two of the lock bits choose the protection mode, and the two are mutually exclusive. Clearing the persistent bit fixes the device in persistent mode. Clearing the password bit fixes it in password mode. A write that would clear both bits, or that would clear one bit after the other is already cleared, is rejected as a whole, and a one-cycle abort pulse is raised. The other two lock bits are a one-time-programmable mode bit and a secure-sector lock. A lock bit only ever goes from 1 to 0, and only reset sets it back to 1.

The password is stored as four 16-bit words. A word is written only when its whole four-cycle program sequence arrives. It can be read back word by word until password mode is locked; after that, password reads return all ones.

Top module: `prot_mode_sel`

## Requirements
- R1: After reset the lock state is 4'b1111, every password word is 16'hFFFF, and `abortPulse`, `rdValid`, `pwdModeOn` and `modeFixed` are all 0.
- R2: An accepted lock write makes the lock state equal to the old state AND `busData[3:0]`, visible one cycle after the strobe. The bit positions are: bit 0 secure-sector lock, bit 1 persistent-mode lock, bit 2 password-mode lock, bit 3 one-time mode bit. `pwdModeOn` equals the inverse of bit 2, and `modeFixed` is 1 when bit 1 or bit 2 is 0.
- R3: A lock write is rejected in three cases: data bits 1 and 2 are both 0; data bit 1 is 0 while lock bit 2 is already 0; or data bit 2 is 0 while lock bit 1 is already 0. A rejected write changes no lock bit, including bits 0 and 3. The cycle after a rejected write, `abortPulse` is 1; in every other cycle it is 0.
- R4: A lock bit never returns from 0 to 1 except through reset. Writing 1 to a bit has no effect.
- R5: An indicator read returns `{12'hFFF, lockState}` on `rdData` one cycle later. A 0 in a bit means that item is protected.
- R6: The first cycle of a password-program sequence is marked by `pwdCycFirst`. A password word is written only on the fourth consecutive cycle of its sequence. The word written is selected by `busAddr` on that fourth cycle (word 0 holds password bits 15:0), and the value written is `busData` on that cycle.
- R7: A sequence that is cut short does not update any word. This covers a sequence ended by `seqCancel`, one restarted by a new first cycle, and sequence cycles that arrive with no first cycle before them.
- R8: A password verify read returns the word selected by `busAddr` one cycle later. It returns 16'hFFFF if password mode was locked before the read's clock edge.
- R9: `rdValid` is 1 exactly in the cycle after a read strobe. When both read strobes come in the same cycle, the password read wins.
- R10: A lock write and a read in the same cycle are both carried out, and the read reports the lock state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset (power cycle) |
| lockWrStb | input | 1 | Program-lock-bits command, one cycle |
| pwdCycStb | input | 1 | One bus cycle of a password-program sequence |
| pwdCycFirst | input | 1 | Marks the first cycle of a password sequence |
| seqCancel | input | 1 | Reset command; abandons a partial password sequence |
| pwdRdStb | input | 1 | Password verify read |
| indRdStb | input | 1 | Protection indicator read |
| busAddr | input | 2 | Password word select |
| busData | input | 16 | Write data word |
| lockState | output | 4 | Current lock bits (0 = programmed) |
| pwdModeOn | output | 1 | Password protection mode is locked in |
| modeFixed | output | 1 | One of the two modes is locked in |
| abortPulse | output | 1 | Lock write was rejected in the previous cycle |
| rdValid | output | 1 | `rdData` carries a fresh read result |
| rdData | output | 16 | Read result |

## Verification
A lock write and a read can land in the same cycle. The most telling case is the write that locks password mode arriving together with a password verify read of a word that was just stored. The bench drives both strobes in one cycle and expects the stored word, and it expects 16'hFFFF from the next read. A lock write paired with an indicator read must likewise report the lock bits as they were before the write. The bench also drives both read strobes in one cycle and judges which one wins by the value returned.

// File: rtl/prot_mode_pkg.sv
package prot_mode_pkg;

  // lock bit positions; neighbours decode these positions
  localparam int SECURE_BIT  = 0;
  localparam int PERSIST_BIT = 1;
  localparam int PWD_BIT     = 2;
  localparam int OTP_BIT     = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic lockCommit;
    logic abortSet;
    logic pwdCommit;
    logic rdPwd;
    logic rdInd;
  } ctrlStb_t;

endpackage

// File: rtl/prot_mode_ctrl.sv
module prot_mode_ctrl
  import prot_mode_pkg::*;
#(
  parameter int LOCK_W  = 4,
  parameter int SEQ_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockWrStb,
  input  logic [LOCK_W-1:0] lockData,
  input  logic [LOCK_W-1:0] lockBits,
  input  logic              pwdCycStb,
  input  logic              pwdCycFirst,
  input  logic              seqCancel,
  input  logic              pwdRdStb,
  input  logic              indRdStb,
  output ctrlStb_t          stb
);

  localparam int CNT_W = $clog2(SEQ_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SEQ_LEN - 1);

  logic [CNT_W-1:0] seqCnt;
  logic persistReq, pwdReq, conflict, lastCyc;

  always_comb begin
    persistReq = !lockData[PERSIST_BIT];
    pwdReq     = !lockData[PWD_BIT];
    conflict   = (persistReq && pwdReq)
              || (persistReq && !lockBits[PWD_BIT])
              || (pwdReq && !lockBits[PERSIST_BIT]);
    lastCyc    = pwdCycStb && !pwdCycFirst && !seqCancel && (seqCnt == LAST_CNT);

    stb.lockCommit = lockWrStb && !conflict;
    stb.abortSet   = lockWrStb && conflict;
    stb.pwdCommit  = lastCyc;
    stb.rdPwd      = pwdRdStb;
    stb.rdInd      = indRdStb && !pwdRdStb;
  end

  // counts the password-sequence cycles seen so far; 0 = no sequence open
  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqCnt <= '0;
    end else if (seqCancel) begin
      seqCnt <= '0;
    end else if (pwdCycStb) begin
      if (pwdCycFirst)          seqCnt <= CNT_W'(1);
      else if (lastCyc)         seqCnt <= '0;
      else if (seqCnt != '0)    seqCnt <= seqCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/prot_mode_dp.sv
module prot_mode_dp
  import prot_mode_pkg::*;
#(
  parameter int LOCK_W    = 4,
  parameter int WORD_W    = 16,
  parameter int PWD_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStb_t                     stb,
  input  logic [LOCK_W-1:0]            lockData,
  input  logic [$clog2(PWD_WORDS)-1:0] selAddr,
  input  logic [WORD_W-1:0]            wrData,
  output logic [LOCK_W-1:0]            lockBits,
  output logic                         abortQ,
  output logic                         rdValid,
  output logic [WORD_W-1:0]            rdData
);

  localparam int PAD_W = WORD_W - LOCK_W;

  logic [WORD_W-1:0] pwdWord [PWD_WORDS];
  logic [WORD_W-1:0] indWord;
  logic              pwdLocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockBits <= '1;
      abortQ   <= 1'b0;
    end else begin
      abortQ <= stb.abortSet;
      if (stb.lockCommit) lockBits <= lockBits & lockData;
    end
  end

  for (genvar g = 0; g < PWD_WORDS; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN)
        pwdWord[g] <= '1;
      else if (stb.pwdCommit && (selAddr == g))
        pwdWord[g] <= wrData;
    end
  end

  always_comb begin
    pwdLocked = !lockBits[PWD_BIT];
    indWord   = {{PAD_W{1'b1}}, lockBits};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '1;
    end else begin
      rdValid <= stb.rdPwd || stb.rdInd;
      if (stb.rdPwd)      rdData <= pwdLocked ? '1 : pwdWord[selAddr];
      else if (stb.rdInd) rdData <= indWord;
    end
  end

endmodule

// File: rtl/prot_mode_sel.sv
module prot_mode_sel
  import prot_mode_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int PWD_WORDS = 4,
  parameter int LOCK_W    = 4,
  parameter int SEQ_LEN   = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         lockWrStb,
  input  logic                         pwdCycStb,
  input  logic                         pwdCycFirst,
  input  logic                         seqCancel,
  input  logic                         pwdRdStb,
  input  logic                         indRdStb,
  input  logic [$clog2(PWD_WORDS)-1:0] busAddr,
  input  logic [WORD_W-1:0]            busData,
  output logic [LOCK_W-1:0]            lockState,
  output logic                         pwdModeOn,
  output logic                         modeFixed,
  output logic                         abortPulse,
  output logic                         rdValid,
  output logic [WORD_W-1:0]            rdData
);

  ctrlStb_t          stb;
  logic [LOCK_W-1:0] lockBits;

  prot_mode_ctrl #(.LOCK_W(LOCK_W), .SEQ_LEN(SEQ_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .lockWrStb(lockWrStb),
    .lockData(busData[LOCK_W-1:0]), .lockBits(lockBits),
    .pwdCycStb(pwdCycStb), .pwdCycFirst(pwdCycFirst), .seqCancel(seqCancel),
    .pwdRdStb(pwdRdStb), .indRdStb(indRdStb), .stb(stb)
  );

  prot_mode_dp #(.LOCK_W(LOCK_W), .WORD_W(WORD_W), .PWD_WORDS(PWD_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lockData(busData[LOCK_W-1:0]),
    .selAddr(busAddr), .wrData(busData), .lockBits(lockBits),
    .abortQ(abortPulse), .rdValid(rdValid), .rdData(rdData)
  );

  assign lockState = lockBits;
  assign pwdModeOn = !lockBits[PWD_BIT];
  assign modeFixed = !lockBits[PWD_BIT] || !lockBits[PERSIST_BIT];

endmodule

// File: rtl/prot_mode_sel_chk.sv
module prot_mode_sel_chk #(
  parameter int WORD_W = 16,
  parameter int LOCK_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              lockWrStb,
  input logic              pwdRdStb,
  input logic              indRdStb,
  input logic [LOCK_W-1:0] lockState,
  input logic              pwdModeOn,
  input logic              abortPulse,
  input logic              rdValid,
  input logic [WORD_W-1:0] rdData
);

  AST_LOCK_MONO: assert property (@(posedge clk) disable iff (!rstN)
    ((~$past(lockState)) & lockState) == '0);                          // R4
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    lockState[1] || lockState[2]);                                      // R3
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> lockState == $past(lockState));                      // R3
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !lockWrStb |=> !abortPulse);                                        // R3
  AST_NO_WR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !lockWrStb |=> $stable(lockState));                                 // R4
  AST_RD_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (pwdRdStb && pwdModeOn) |=> rdData == '1);                          // R8
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (pwdRdStb || indRdStb) |=> rdValid);                                // R9
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(pwdRdStb || indRdStb) |=> !rdValid);                              // R9
  AST_IND_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (indRdStb && !pwdRdStb) |=> rdData == {{(WORD_W-LOCK_W){1'b1}}, $past(lockState)}); // R5

endmodule

bind prot_mode_sel prot_mode_sel_chk #(.WORD_W(WORD_W), .LOCK_W(LOCK_W)) u_chk (
  .clk(clk), .rstN(rstN), .lockWrStb(lockWrStb), .pwdRdStb(pwdRdStb),
  .indRdStb(indRdStb), .lockState(lockState), .pwdModeOn(pwdModeOn),
  .abortPulse(abortPulse), .rdValid(rdValid), .rdData(rdData)
);

// File: tb/tb_prot_mode_sel.sv
module tb_prot_mode_sel;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 16;
  // {op[1:0], addr[1:0], data[15:0], expRd[15:0], expLock[3:0], expAbort}
  // op 0 = lock write, 1 = password word, 2 = password read, 3 = indicator read
  localparam logic [40:0] VEC [N_VEC] = '{
    {2'd1, 2'd0, 16'h1234, 16'h0000, 4'hF, 1'b0},
    {2'd1, 2'd1, 16'h5678, 16'h0000, 4'hF, 1'b0},
    {2'd1, 2'd2, 16'h9ABC, 16'h0000, 4'hF, 1'b0},
    {2'd1, 2'd3, 16'hDEF0, 16'h0000, 4'hF, 1'b0},
    {2'd2, 2'd2, 16'h0000, 16'h9ABC, 4'hF, 1'b0},
    {2'd2, 2'd0, 16'h0000, 16'h1234, 4'hF, 1'b0},
    {2'd3, 2'd0, 16'h0000, 16'hFFFF, 4'hF, 1'b0},
    {2'd0, 2'd0, 16'hFFFE, 16'h0000, 4'hE, 1'b0},
    {2'd3, 2'd0, 16'h0000, 16'hFFFE, 4'hE, 1'b0},
    {2'd0, 2'd0, 16'hFFF9, 16'h0000, 4'hE, 1'b1},
    {2'd0, 2'd0, 16'hFFF7, 16'h0000, 4'h6, 1'b0},
    {2'd0, 2'd0, 16'hFFFF, 16'h0000, 4'h6, 1'b0},
    {2'd0, 2'd0, 16'hFFFB, 16'h0000, 4'h2, 1'b0},
    {2'd0, 2'd0, 16'hFFFD, 16'h0000, 4'h2, 1'b1},
    {2'd2, 2'd1, 16'h0000, 16'hFFFF, 4'h2, 1'b0},
    {2'd3, 2'd0, 16'h0000, 16'hFFF2, 4'h2, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lockWrStb = 1'b0, pwdCycStb = 1'b0, pwdCycFirst = 1'b0, seqCancel = 1'b0;
  logic pwdRdStb = 1'b0, indRdStb = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busData = '0;
  logic [3:0]  lockState;
  logic        pwdModeOn, modeFixed, abortPulse, rdValid;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  prot_mode_sel dut (
    .clk(clk), .rstN(rstN), .lockWrStb(lockWrStb), .pwdCycStb(pwdCycStb),
    .pwdCycFirst(pwdCycFirst), .seqCancel(seqCancel), .pwdRdStb(pwdRdStb),
    .indRdStb(indRdStb), .busAddr(busAddr), .busData(busData),
    .lockState(lockState), .pwdModeOn(pwdModeOn), .modeFixed(modeFixed),
    .abortPulse(abortPulse), .rdValid(rdValid), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic lockWr(input logic [15:0] d);
    lockWrStb = 1'b1; busData = d;
    @(negedge clk);
    lockWrStb = 1'b0;
  endtask

  task automatic pwdCyc(input logic first, input logic [1:0] a, input logic [15:0] d);
    pwdCycStb = 1'b1; pwdCycFirst = first; busAddr = a; busData = d;
    @(negedge clk);
    pwdCycStb = 1'b0; pwdCycFirst = 1'b0;
  endtask

  task automatic pwdWord(input logic [1:0] a, input logic [15:0] d);
    pwdCyc(1'b1, a, d);
    for (int k = 0; k < 3; k++) pwdCyc(1'b0, a, d);
  endtask

  task automatic pwdRd(input logic [1:0] a);
    pwdRdStb = 1'b1; busAddr = a;
    @(negedge clk);
    pwdRdStb = 1'b0;
  endtask

  task automatic indRd();
    indRdStb = 1'b1;
    @(negedge clk);
    indRdStb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();

    // table walk
    for (int i = 0; i < N_VEC; i++) begin
      logic [1:0] op; logic [1:0] a; logic [15:0] d, expRd; logic [3:0] expLock; logic expAb;
      {op, a, d, expRd, expLock, expAb} = VEC[i];
      case (op)
        2'd0: begin
          lockWr(d);
          check($sformatf("R2/R3/R4 lock row %0d", i), {12'h0, lockState}, {12'h0, expLock});
          check($sformatf("R3 abort row %0d", i), {15'h0, abortPulse}, {15'h0, expAb});
        end
        2'd1: begin
          pwdWord(a, d);
          check($sformatf("R6 lock after word row %0d", i), {12'h0, lockState}, {12'h0, expLock});
        end
        2'd2: begin
          pwdRd(a);
          check($sformatf("R8 verify row %0d", i), rdData, expRd);
        end
        default: begin
          indRd();
          check($sformatf("R5 indicator row %0d", i), rdData, expRd);
        end
      endcase
    end

    // R1 reset state
    doReset();
    check("R1 lockState", {12'h0, lockState}, 16'h000F);
    check("R1 flags", {12'h0, pwdModeOn, modeFixed, abortPulse, rdValid}, 16'h0000);
    pwdRd(2'd3);
    check("R1 password word reset", rdData, 16'hFFFF);
    check("R9 rdValid after read", {15'h0, rdValid}, 16'h0001);
    @(negedge clk);
    check("R9 rdValid idle", {15'h0, rdValid}, 16'h0000);

    // R7 cancelled sequence
    pwdCyc(1'b1, 2'd1, 16'hAAAA);
    pwdCyc(1'b0, 2'd1, 16'hAAAA);
    pwdCyc(1'b0, 2'd1, 16'hAAAA);
    seqCancel = 1'b1; @(negedge clk); seqCancel = 1'b0;
    pwdCyc(1'b0, 2'd1, 16'hAAAA);
    pwdRd(2'd1);
    check("R7 cancel leaves word", rdData, 16'hFFFF);
    // R7 cycles with no first
    for (int k = 0; k < 4; k++) pwdCyc(1'b0, 2'd1, 16'hBBBB);
    pwdRd(2'd1);
    check("R7 orphan cycles ignored", rdData, 16'hFFFF);
    // R7 restart: three cycles then a new sequence
    pwdCyc(1'b1, 2'd1, 16'hCCCC);
    pwdCyc(1'b0, 2'd1, 16'hCCCC);
    pwdCyc(1'b0, 2'd1, 16'hCCCC);
    pwdCyc(1'b1, 2'd1, 16'h4444);
    pwdRd(2'd1);
    check("R7 restart does not commit", rdData, 16'hFFFF);
    pwdCyc(1'b0, 2'd1, 16'h4444);
    pwdCyc(1'b0, 2'd1, 16'h4444);
    pwdCyc(1'b0, 2'd1, 16'h4444);
    pwdRd(2'd1);
    check("R6 restarted sequence commits", rdData, 16'h4444);

    // R6 address and data of the fourth cycle
    pwdCyc(1'b1, 2'd0, 16'h1111);
    pwdCyc(1'b0, 2'd0, 16'h1111);
    pwdCyc(1'b0, 2'd0, 16'h1111);
    pwdCyc(1'b0, 2'd2, 16'h2222);
    pwdRd(2'd2);
    check("R6 fourth-cycle word", rdData, 16'h2222);
    pwdRd(2'd0);
    check("R6 other word untouched", rdData, 16'hFFFF);

    // R2 persistent mode, R3 conflicting password request
    lockWr(16'hFFFD);
    check("R2 persistent lock", {12'h0, lockState}, 16'h000D);
    check("R2 mode flags persistent", {14'h0, pwdModeOn, modeFixed}, 16'h0001);
    lockWr(16'hFFFA);
    check("R3 reject keeps bit 0", {12'h0, lockState}, 16'h000D);
    check("R3 abort pulse", {15'h0, abortPulse}, 16'h0001);
    @(negedge clk);
    check("R3 abort one cycle", {15'h0, abortPulse}, 16'h0000);
    pwdRd(2'd1);
    check("R8 read open in persistent mode", rdData, 16'h4444);

    // R4 reset restores bits
    doReset();
    check("R4 reset restores", {12'h0, lockState}, 16'h000F);

    // R10 lock write and verify read in one cycle
    pwdWord(2'd0, 16'hBEEF);
    lockWrStb = 1'b1; busData = 16'hFFFB; pwdRdStb = 1'b1; busAddr = 2'd0;
    @(negedge clk);
    lockWrStb = 1'b0; pwdRdStb = 1'b0;
    check("R10 read sees state before lock", rdData, 16'hBEEF);
    check("R2 password mode locked", {12'h0, lockState}, 16'h000B);
    check("R2 mode flags password", {14'h0, pwdModeOn, modeFixed}, 16'h0003);
    pwdRd(2'd0);
    check("R8 read blocked", rdData, 16'hFFFF);

    // R10 lock write and indicator read in one cycle
    lockWrStb = 1'b1; busData = 16'hFFFE; indRdStb = 1'b1;
    @(negedge clk);
    lockWrStb = 1'b0; indRdStb = 1'b0;
    check("R10 indicator sees old bits", rdData, 16'hFFFB);
    check("R2 secure bit programmed", {12'h0, lockState}, 16'h000A);

    // R9 both reads at once: password read wins
    pwdRdStb = 1'b1; indRdStb = 1'b1; busAddr = 2'd0;
    @(negedge clk);
    pwdRdStb = 1'b0; indRdStb = 1'b0;
    check("R9 password read wins", rdData, 16'hFFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule